// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital side of an eight-input successive-approximation converter. After a trigger it takes every enabled input in ascending order. For each input it routes the channel select to the analog multiplexer and holds a sample window of programmable length. It then runs a binary search from the most significant bit down. Each step drives a trial code to the DAC and reads back a single comparator bit.

The trigger can come from one of four sources: a software strobe, a rising edge on an asynchronous external pin, a timer pulse or a PWM event pulse. Configuration chooses the source. In sleep mode the analog cell is powered only while a sequence runs, and a programmable wake-up delay comes before the first sample. Each result is written to a shared last-result register and to a register kept for its channel. Flags report completion and overruns, and reading the matching register clears them.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, `busy`, `dataReady`, `lastOvr`, `eocFlags`, `chanOvr`, `dacCode` and `lastData` are all zero.
- R2: With `cfgLowRes`=0, the stored result equals the largest 10-bit code that the comparator reports as at or below the input.
- R3: With `cfgLowRes`=1, only eight steps run (bits 9 down to 2), and the result is those eight bits right-justified (input code divided by 4).
- R4: A finished conversion writes `lastData`, `lastChan` and the channel's own register (read on `chanData` when `rdChanSel` selects it), and sets `eocFlags[channel]` and `dataReady`.
- R5: `cfgTrigSel` selects the start source: 0 = `swStart`, 1 = rising edge of `extTrig`, 2 = `timerTrig`, 3 = `pwmTrig`. Sources that are not selected have no effect.
- R6: One trigger converts every channel set in `cfgChanEn`, lowest index first, with no idle cycle between channels. Without sleep, `busy` lasts (cfgShold+1+steps) cycles per channel. A trigger with no channel enabled is ignored.
- R7: Before the search of each channel, `sampleEn` is high for exactly cfgShold+1 cycles.
- R8: With `cfgSleep`=1, `anaPowerOn` is low while idle, and `busy` runs for cfgStartup+1 cycles before the first `sampleEn`. With `cfgSleep`=0, `anaPowerOn` stays high.
- R9: The first trial code after sampling is 512 (bit 9 alone). A bit is kept when `cmpIn`=1 and cleared otherwise.
- R10: `extTrig` passes through two synchronising flops. `busy` rises on the third clock edge after a 0-to-1 change, and a level held high does not trigger again.
- R11: A one-cycle `rdLast` clears `dataReady`, and a one-cycle `rdChan` clears `eocFlags[rdChanSel]`.
- R12: `chanOvr[ch]` is set when channel ch is stored while its flag is still set, and `lastOvr` is set when a result is stored while `dataReady` is still set. The matching read clears each one.
- R13: A trigger that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgChanEn | input | 8 | Channels taken by the sequencer |
| cfgLowRes | input | 1 | 1 = 8-bit search, 0 = 10-bit |
| cfgTrigSel | input | 2 | Start source select |
| cfgSleep | input | 1 | Power the analog cell down while idle |
| cfgStartup | input | STARTUP_W | Wake-up delay minus one |
| cfgShold | input | SHOLD_W | Sample window minus one |
| swStart | input | 1 | Software start strobe |
| extTrig | input | 1 | Asynchronous external trigger pin |
| timerTrig | input | 1 | Timer trigger pulse |
| pwmTrig | input | 1 | PWM event pulse |
| cmpIn | input | 1 | Comparator: input at or above DAC level |
| rdLast | input | 1 | Read strobe for the last result |
| rdChan | input | 1 | Read strobe for the selected channel |
| rdChanSel | input | 3 | Channel shown on chanData |
| anaPowerOn | output | 1 | Analog cell power enable |
| anaChan | output | 3 | Multiplexer select |
| sampleEn | output | 1 | Sample-and-hold window |
| dacCode | output | 10 | Trial code to the DAC |
| busy | output | 1 | Sequence in progress |
| lastData | output | 10 | Most recent result |
| lastChan | output | 3 | Channel of the most recent result |
| chanData | output | 10 | Result of channel rdChanSel |
| eocFlags | output | 8 | Per-channel completion flags |
| dataReady | output | 1 | Unread last result |
| chanOvr | output | 8 | Per-channel overrun flags |
| lastOvr | output | 1 | Last-result overrun |
| eocIrq | output | 1 | Any completion flag set |

## Verification
The assertions assume that the configuration inputs do not change while `busy` is high. The bench changes them only while the block is idle. They also assume that `cmpIn` depends only on the current `dacCode` and channel, so the bench models the comparator as a direct compare between a per-channel input code and `dacCode`. The software, timer and PWM triggers are taken to be synchronous one-cycle pulses, and the bench drives them only on falling clock edges. The bench holds read strobes for a single cycle.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int NUM_CH   = 8;
  localparam int CH_W     = $clog2(NUM_CH);
  localparam int RES_BITS = 10;
  localparam int LOW_BITS = 8;
  localparam int LOW_STOP = RES_BITS - LOW_BITS;
  localparam int BIT_W    = $clog2(RES_BITS);

  localparam logic [1:0] TRIG_SW  = 2'd0;
  localparam logic [1:0] TRIG_EXT = 2'd1;
  localparam logic [1:0] TRIG_TMR = 2'd2;
  localparam logic [1:0] TRIG_PWM = 2'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_WAKE, ST_SAMPLE, ST_STEP} sarState_t;

  typedef struct packed {
    logic             clearCode;
    logic             stepEn;
    logic [BIT_W-1:0] bitIdx;
    logic             store;
    logic [CH_W-1:0]  chan;
    logic             lowRes;
  } sarStrobe_t;
endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl import sar_pkg::*; #(
  parameter int STARTUP_W = 8,
  parameter int SHOLD_W   = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_CH-1:0]    cfgChanEn,
  input  logic                 cfgLowRes,
  input  logic [1:0]           cfgTrigSel,
  input  logic                 cfgSleep,
  input  logic [STARTUP_W-1:0] cfgStartup,
  input  logic [SHOLD_W-1:0]   cfgShold,
  input  logic                 swStart,
  input  logic                 extTrig,
  input  logic                 timerTrig,
  input  logic                 pwmTrig,
  output sarStrobe_t           strobe,
  output logic                 anaPowerOn,
  output logic                 sampleEn,
  output logic [CH_W-1:0]      anaChan,
  output logic                 busy
);
  localparam int CNT_W = (STARTUP_W > SHOLD_W) ? STARTUP_W : SHOLD_W;
  localparam logic [BIT_W-1:0] TOP_BIT  = BIT_W'(RES_BITS - 1);
  localparam logic [BIT_W-1:0] STOP_LOW = BIT_W'(LOW_STOP);

  sarState_t         state;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  bitIdx;
  logic [CH_W-1:0]   curCh;
  logic [NUM_CH-1:0] seqMask;
  logic              resLow;
  logic [1:0]        extSync;
  logic              extPrev;
  logic              extRise;
  logic              trigHit;
  logic              startOk;
  logic              lastStep;
  logic [BIT_W-1:0]  stopIdx;
  logic [CH_W:0]     firstPick;
  logic [CH_W:0]     nextPick;

  // lowest set bit of mask at or above index 'from'; MSB of result = found
  function automatic logic [CH_W:0] pickLowest(input logic [NUM_CH-1:0] mask, input int from);
    logic [CH_W:0] r;
    r = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (mask[i] && i >= from) r = {1'b1, CH_W'(i)};
    end
    return r;
  endfunction

  // two-flop synchroniser plus edge memory for the external pin
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extSync <= '0;
      extPrev <= 1'b0;
    end else begin
      extSync <= {extSync[0], extTrig};
      extPrev <= extSync[1];
    end
  end
  assign extRise = extSync[1] & ~extPrev;

  always_comb begin
    case (cfgTrigSel)
      TRIG_SW:  trigHit = swStart;
      TRIG_EXT: trigHit = extRise;
      TRIG_TMR: trigHit = timerTrig;
      default:  trigHit = pwmTrig;
    endcase
  end

  assign firstPick = pickLowest(cfgChanEn, 0);
  assign nextPick  = pickLowest(seqMask, int'(curCh) + 1);
  assign startOk   = (state == ST_IDLE) && trigHit && firstPick[CH_W];
  assign stopIdx   = resLow ? STOP_LOW : '0;
  assign lastStep  = (state == ST_STEP) && (bitIdx == stopIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bitIdx  <= '0;
      curCh   <= '0;
      seqMask <= '0;
      resLow  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (startOk) begin
          seqMask <= cfgChanEn;
          curCh   <= firstPick[CH_W-1:0];
          resLow  <= cfgLowRes;
          if (cfgSleep) begin
            state <= ST_WAKE;
            cnt   <= CNT_W'(cfgStartup);
          end else begin
            state <= ST_SAMPLE;
            cnt   <= CNT_W'(cfgShold);
          end
        end
        ST_WAKE: begin
          if (cnt == '0) begin
            state <= ST_SAMPLE;
            cnt   <= CNT_W'(cfgShold);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_SAMPLE: begin
          if (cnt == '0) begin
            state  <= ST_STEP;
            bitIdx <= TOP_BIT;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (lastStep) begin
            if (nextPick[CH_W]) begin
              curCh <= nextPick[CH_W-1:0];
              state <= ST_SAMPLE;
              cnt   <= CNT_W'(cfgShold);
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            bitIdx <= bitIdx - 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    strobe.clearCode = (state == ST_SAMPLE);
    strobe.stepEn    = (state == ST_STEP);
    strobe.bitIdx    = bitIdx;
    strobe.store     = lastStep;
    strobe.chan      = curCh;
    strobe.lowRes    = resLow;
  end

  assign busy       = (state != ST_IDLE);
  assign sampleEn   = (state == ST_SAMPLE);
  assign anaChan    = curCh;
  assign anaPowerOn = !cfgSleep || busy;

  p_sample_enabled_r6: assert property (@(posedge clk) disable iff (!rstN)
    sampleEn |-> seqMask[anaChan]);
  p_chan_held_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STEP && !lastStep) |=> $stable(anaChan));
  p_busy_ignores_trig_r13: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !lastStep) |=> $stable(seqMask));
  p_wake_in_sleep_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAKE) |-> cfgSleep);
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath import sar_pkg::*; (
  input  logic                clk,
  input  logic                rstN,
  input  sarStrobe_t          strobe,
  input  logic                cmpIn,
  input  logic                rdLast,
  input  logic                rdChan,
  input  logic [CH_W-1:0]     rdChanSel,
  output logic [RES_BITS-1:0] dacCode,
  output logic [RES_BITS-1:0] lastData,
  output logic [CH_W-1:0]     lastChan,
  output logic [RES_BITS-1:0] chanData,
  output logic [NUM_CH-1:0]   eocFlags,
  output logic                dataReady,
  output logic [NUM_CH-1:0]   chanOvr,
  output logic                lastOvr
);
  logic [RES_BITS-1:0] codeReg;
  logic [RES_BITS-1:0] trialCode;
  logic [RES_BITS-1:0] keptCode;
  logic [RES_BITS-1:0] finalVal;
  logic [RES_BITS-1:0] chanRegs [NUM_CH];

  assign trialCode = codeReg | (RES_BITS'(1) << strobe.bitIdx);
  assign dacCode   = strobe.stepEn ? trialCode : codeReg;
  assign keptCode  = cmpIn ? trialCode : codeReg;
  assign finalVal  = strobe.lowRes ? (keptCode >> LOW_STOP) : keptCode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeReg <= '0;
    end else if (strobe.clearCode) begin
      codeReg <= '0;
    end else if (strobe.stepEn) begin
      codeReg <= keptCode;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastData  <= '0;
      lastChan  <= '0;
      dataReady <= 1'b0;
      lastOvr   <= 1'b0;
    end else begin
      if (strobe.store) begin
        lastData  <= finalVal;
        lastChan  <= strobe.chan;
        dataReady <= 1'b1;
        if (dataReady && !rdLast) lastOvr <= 1'b1;
      end else if (rdLast) begin
        dataReady <= 1'b0;
        lastOvr   <= 1'b0;
      end
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic hit;
    logic rd;
    assign hit = strobe.store && (strobe.chan == CH_W'(ch));
    assign rd  = rdChan && (rdChanSel == CH_W'(ch));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chanRegs[ch] <= '0;
        eocFlags[ch] <= 1'b0;
        chanOvr[ch]  <= 1'b0;
      end else if (hit) begin
        chanRegs[ch] <= finalVal;
        eocFlags[ch] <= 1'b1;
        if (eocFlags[ch] && !rd) chanOvr[ch] <= 1'b1;
      end else if (rd) begin
        eocFlags[ch] <= 1'b0;
        chanOvr[ch]  <= 1'b0;
      end
    end
  end

  assign chanData = chanRegs[rdChanSel];

  p_trial_bit_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepEn |-> dacCode[strobe.bitIdx]);
  p_low_floor_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepEn && strobe.lowRes) |-> (strobe.bitIdx >= BIT_W'(LOW_STOP)));
  p_store_flags_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.store |=> (eocFlags[$past(strobe.chan)] && dataReady));
  p_ovr_on_unread_r12: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.store && eocFlags[strobe.chan] && !(rdChan && rdChanSel == strobe.chan))
      |=> chanOvr[$past(strobe.chan)]);
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl import sar_pkg::*; #(
  parameter int STARTUP_W = 8,
  parameter int SHOLD_W   = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_CH-1:0]    cfgChanEn,
  input  logic                 cfgLowRes,
  input  logic [1:0]           cfgTrigSel,
  input  logic                 cfgSleep,
  input  logic [STARTUP_W-1:0] cfgStartup,
  input  logic [SHOLD_W-1:0]   cfgShold,
  input  logic                 swStart,
  input  logic                 extTrig,
  input  logic                 timerTrig,
  input  logic                 pwmTrig,
  input  logic                 cmpIn,
  input  logic                 rdLast,
  input  logic                 rdChan,
  input  logic [CH_W-1:0]      rdChanSel,
  output logic                 anaPowerOn,
  output logic [CH_W-1:0]      anaChan,
  output logic                 sampleEn,
  output logic [RES_BITS-1:0]  dacCode,
  output logic                 busy,
  output logic [RES_BITS-1:0]  lastData,
  output logic [CH_W-1:0]      lastChan,
  output logic [RES_BITS-1:0]  chanData,
  output logic [NUM_CH-1:0]    eocFlags,
  output logic                 dataReady,
  output logic [NUM_CH-1:0]    chanOvr,
  output logic                 lastOvr,
  output logic                 eocIrq
);
  sarStrobe_t strobe;

  sar_ctrl #(.STARTUP_W(STARTUP_W), .SHOLD_W(SHOLD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgChanEn(cfgChanEn), .cfgLowRes(cfgLowRes),
    .cfgTrigSel(cfgTrigSel), .cfgSleep(cfgSleep), .cfgStartup(cfgStartup),
    .cfgShold(cfgShold), .swStart(swStart), .extTrig(extTrig),
    .timerTrig(timerTrig), .pwmTrig(pwmTrig), .strobe(strobe),
    .anaPowerOn(anaPowerOn), .sampleEn(sampleEn), .anaChan(anaChan), .busy(busy)
  );

  sar_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmpIn(cmpIn),
    .rdLast(rdLast), .rdChan(rdChan), .rdChanSel(rdChanSel),
    .dacCode(dacCode), .lastData(lastData), .lastChan(lastChan),
    .chanData(chanData), .eocFlags(eocFlags), .dataReady(dataReady),
    .chanOvr(chanOvr), .lastOvr(lastOvr)
  );

  assign eocIrq = |eocFlags;

  p_sample_powered_r8: assert property (@(posedge clk) disable iff (!rstN)
    sampleEn |-> anaPowerOn);
  p_idle_no_sample_r6: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sampleEn);
endmodule

// File: tb/sar_conv_ctrl_bench.sv
module sar_conv_ctrl_bench;
  import sar_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_CH-1:0] cfgChanEn = '0;
  logic cfgLowRes = 1'b0;
  logic [1:0] cfgTrigSel = TRIG_SW;
  logic cfgSleep = 1'b0;
  logic [7:0] cfgStartup = 8'd5;
  logic [3:0] cfgShold = 4'd3;
  logic swStart = 1'b0, extTrig = 1'b0, timerTrig = 1'b0, pwmTrig = 1'b0;
  logic cmpIn;
  logic rdLast = 1'b0, rdChan = 1'b0;
  logic [CH_W-1:0] rdChanSel = '0;
  logic anaPowerOn, sampleEn, busy, dataReady, lastOvr, eocIrq;
  logic [CH_W-1:0] anaChan, lastChan;
  logic [RES_BITS-1:0] dacCode, lastData, chanData;
  logic [NUM_CH-1:0] eocFlags, chanOvr;
  logic [RES_BITS-1:0] vin [NUM_CH];

  int nChecks = 0;
  int nFail = 0;
  int busyCyc, preSample, sampCyc, firstDac;

  always #5 clk = ~clk;

  assign cmpIn = (vin[anaChan] >= dacCode);

  sar_conv_ctrl u_sar_conv_ctrl (
    .clk(clk), .rstN(rstN), .cfgChanEn(cfgChanEn), .cfgLowRes(cfgLowRes),
    .cfgTrigSel(cfgTrigSel), .cfgSleep(cfgSleep), .cfgStartup(cfgStartup),
    .cfgShold(cfgShold), .swStart(swStart), .extTrig(extTrig),
    .timerTrig(timerTrig), .pwmTrig(pwmTrig), .cmpIn(cmpIn),
    .rdLast(rdLast), .rdChan(rdChan), .rdChanSel(rdChanSel),
    .anaPowerOn(anaPowerOn), .anaChan(anaChan), .sampleEn(sampleEn),
    .dacCode(dacCode), .busy(busy), .lastData(lastData), .lastChan(lastChan),
    .chanData(chanData), .eocFlags(eocFlags), .dataReady(dataReady),
    .chanOvr(chanOvr), .lastOvr(lastOvr), .eocIrq(eocIrq)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk) sig = 1'b1;
    @(negedge clk) sig = 1'b0;
  endtask

  // runs from a negedge until busy drops, recording timing of the run
  task automatic waitDone();
    bit prevSamp = 0;
    bit seenSamp = 0;
    busyCyc = 0; preSample = 0; sampCyc = 0; firstDac = -1;
    for (int i = 0; i < 2000 && busy; i++) begin
      busyCyc++;
      if (sampleEn) begin sampCyc++; seenSamp = 1; end
      else if (!seenSamp) preSample++;
      if (prevSamp && !sampleEn && firstDac < 0) firstDac = int'(dacCode);
      prevSamp = sampleEn;
      @(negedge clk);
    end
  endtask

  task automatic readChan(input int ch);
    @(negedge clk) begin rdChanSel = CH_W'(ch); rdChan = 1'b1; end
    @(negedge clk) rdChan = 1'b0;
  endtask

  task automatic clearAll();
    for (int c = 0; c < NUM_CH; c++) readChan(c);
    pulse(rdLast);
  endtask

  task automatic idleCheck(input string req, input int n);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (busy) hits++;
    end
    chk(req, hits, 0);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 dataReady", dataReady, 0);
    chk("R1 eocFlags", eocFlags, 0);
    chk("R1 chanOvr", chanOvr, 0);
    chk("R1 lastOvr", lastOvr, 0);
    chk("R1 dacCode", dacCode, 0);
    chk("R1 lastData", lastData, 0);
    chk("R8 power no sleep", anaPowerOn, 1);
  endtask

  task automatic t_full();
    cfgChanEn = 8'h08; cfgLowRes = 0; vin[3] = 10'd717;
    pulse(swStart);
    waitDone();
    chk("R6 busy cycles full", busyCyc, 4 + 10);
    chk("R7 sample cycles", sampCyc, 4);
    chk("R8 no wake delay", preSample, 0);
    chk("R9 first trial code", firstDac, 512);
    chk("R2 lastData", lastData, 717);
    chk("R4 lastChan", lastChan, 3);
    rdChanSel = 3; #1;
    chk("R4 chanData", chanData, 717);
    chk("R4 eocFlags", eocFlags, 8'h08);
    chk("R4 dataReady", dataReady, 1);
    chk("R4 eocIrq", eocIrq, 1);
    pulse(rdLast);
    chk("R11 dataReady cleared", dataReady, 0);
    chk("R11 eoc kept", eocFlags, 8'h08);
    readChan(3);
    chk("R11 eoc cleared", eocFlags, 0);
  endtask

  task automatic t_low();
    cfgChanEn = 8'h20; cfgLowRes = 1; vin[5] = 10'd717;
    pulse(swStart);
    waitDone();
    chk("R3 busy cycles low", busyCyc, 4 + 8);
    chk("R3 low result", lastData, 179);
    cfgLowRes = 0;
    clearAll();
  endtask

  task automatic t_seq();
    cfgChanEn = 8'b1010_0101;
    vin[0] = 10'd0; vin[2] = 10'd1023; vin[5] = 10'd300; vin[7] = 10'd513;
    pulse(swStart);
    waitDone();
    chk("R6 seq busy cycles", busyCyc, 4 * 14);
    chk("R6 seq eocFlags", eocFlags, 8'b1010_0101);
    chk("R6 last channel", lastChan, 7);
    rdChanSel = 0; #1; chk("R2 ch0 zero", chanData, 0);
    rdChanSel = 2; #1; chk("R2 ch2 full", chanData, 1023);
    rdChanSel = 5; #1; chk("R2 ch5", chanData, 300);
    rdChanSel = 7; #1; chk("R2 ch7", chanData, 513);
    chk("R12 lastOvr", lastOvr, 1);
    chk("R12 no chanOvr", chanOvr, 0);
    cfgChanEn = 8'h01;
    pulse(swStart);
    waitDone();
    chk("R12 chanOvr ch0", chanOvr, 8'h01);
    readChan(0);
    chk("R12 chanOvr cleared", chanOvr, 0);
    pulse(rdLast);
    chk("R12 lastOvr cleared", lastOvr, 0);
    clearAll();
  endtask

  task automatic t_mask0();
    cfgChanEn = 8'h00;
    pulse(swStart);
    idleCheck("R6 empty mask ignored", 6);
  endtask

  task automatic t_trigsel();
    cfgChanEn = 8'h02; vin[1] = 10'd42; cfgTrigSel = TRIG_TMR;
    pulse(swStart);
    pulse(pwmTrig);
    @(negedge clk) extTrig = 1'b1;
    idleCheck("R5 unselected sources", 6);
    @(negedge clk) extTrig = 1'b0;
    pulse(timerTrig);
    chk("R5 timer starts", busy, 1);
    waitDone();
    chk("R5 timer result", lastData, 42);
    cfgTrigSel = TRIG_PWM; vin[1] = 10'd99;
    pulse(timerTrig);
    idleCheck("R5 timer ignored under pwm", 4);
    pulse(pwmTrig);
    chk("R5 pwm starts", busy, 1);
    waitDone();
    chk("R5 pwm result", lastData, 99);
    clearAll();
  endtask

  task automatic t_ext();
    int lat = 0;
    cfgChanEn = 8'h40; vin[6] = 10'd600; cfgTrigSel = TRIG_EXT;
    repeat (4) @(negedge clk);
    extTrig = 1'b1;
    for (int i = 0; i < 10 && !busy; i++) begin
      @(negedge clk);
      lat++;
    end
    chk("R10 sync latency", lat, 3);
    waitDone();
    chk("R10 ext result", lastData, 600);
    idleCheck("R10 held level no retrigger", 20);
    @(negedge clk) extTrig = 1'b0;
    repeat (3) @(negedge clk);
    vin[6] = 10'd5;
    extTrig = 1'b1;
    repeat (4) @(negedge clk);
    waitDone();
    chk("R10 second edge", lastData, 5);
    extTrig = 1'b0;
    cfgTrigSel = TRIG_SW;
    clearAll();
  endtask

  task automatic t_busy_ignore();
    int extra = 0;
    cfgChanEn = 8'h10; vin[4] = 10'd256;
    pulse(swStart);
    repeat (3) @(negedge clk);
    swStart = 1'b1;
    @(negedge clk) swStart = 1'b0;
    waitDone();
    chk("R13 single run", busyCyc + 4, 14);
    idleCheck("R13 no restart", 10);
    chk("R13 result", lastData, 256);
    clearAll();
  endtask

  task automatic t_sleep();
    cfgSleep = 1; cfgChanEn = 8'h01; vin[0] = 10'd1000;
    @(negedge clk);
    chk("R8 power off idle", anaPowerOn, 0);
    pulse(swStart);
    chk("R8 power on busy", anaPowerOn, 1);
    waitDone();
    chk("R8 wake cycles", preSample, 6);
    chk("R8 total cycles", busyCyc, 6 + 14);
    chk("R8 power off after", anaPowerOn, 0);
    chk("R2 sleep result", lastData, 1000);
    cfgSleep = 0;
    clearAll();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    for (int c = 0; c < NUM_CH; c++) vin[c] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_full();
    t_low();
    t_seq();
    t_mask0();
    t_trigsel();
    t_ext();
    t_busy_ignore();
    t_sleep();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule